// File: doc/BRIEF.md
# Oscillator frequency measurement unit

This unit measures how fast a free-running on-chip oscillator runs by counting its rising edges over a window timed by the reference clock. Software writes the window length in reference cycles and sets the start bits. At the end of the window the unit raises a done flag and holds the edge count for reading. The reference clock runs at 24 MHz in the target system, so 24 reference cycles make one microsecond.

The oscillator counter runs in the oscillator domain. Its value crosses into the reference domain as a Gray code. The same unit divides the oscillator by a programmable ratio to make a one-cycle enable pulse. A select bit routes either that pulse or an external 32 kHz input to the slow-clock output.

Control writes carry a per-bit write-enable mask in the upper half-word. Status and result are read-only.

Top module: `osc_freq_meter`

## Requirements

Register map (byte address on `bus_addr`):

| Address | Register | Contents |
|---------|----------|----------|
| 0x00 | control | bit 0 start, bit 1 oscillator enable, bits [7:2] divide field |
| 0x04 | window length | length in reference cycles, WIN_W bits |
| 0x08 | select | bit 6 picks the slow-clock source |
| 0x10 | status | bit 0 done |
| 0x14 | result | edge count |

- R1: After reset every register reads 0, `osc_run` is 0 and `slow_src` follows `ext_slow_clk`.
- R2: Control and select take masked writes. Write-data bit 16+i enables update of bit i. Only enabled bits change. Reads return 0 in bits [31:16] and in every bit that is not implemented.
- R3: The window length register takes a plain full-word write. Bits above WIN_W read 0. A length of 0 acts as a length of 1.
- R4: A write that leaves control bits [1:0] at 2'b11, with bit 0 enabled and written 1, starts a measurement. Status bit 0 reads 1 exactly L reference cycles after the write edge, where L is the window length, and not before.
- R5: The result register holds the number of oscillator rising edges in the window, within ±2. It stays frozen while done is set.
- R6: Writing control bits [1:0] to 2'b00 clears done. Status reads 0 one cycle after that write.
- R7: A new start write during a measurement restarts the window from zero. Done then appears L cycles after the new write.
- R8: Control bit 1 on its own sets `osc_run` and runs the oscillator logic without starting a measurement, so done stays 0.
- R9: While the oscillator is enabled, `osc_div_en` pulses for one oscillator cycle every N oscillator cycles. N is control bits [7:2], and a field of 0 means N = 1.
- R10: Select bit 6 = 0 routes `ext_slow_clk` to `slow_src`. Select bit 6 = 1 routes `osc_div_en` to `slow_src`.
- R11: Writes to status (0x10) and result (0x14) change nothing.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| osc_clk | input | 1 | Oscillator being measured |
| ext_slow_clk | input | 1 | External 32 kHz source |
| bus_wr | input | 1 | Write strobe, sampled on `clk` |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data; bits [31:16] are the write mask for masked registers |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| osc_run | output | 1 | Oscillator enable (control bit 1) |
| osc_div_en | output | 1 | Divided oscillator enable pulse, in the `osc_clk` domain |
| slow_src | output | 1 | Selected slow-clock source |

## Verification

- A wrong window count shows on the status register, because done arrives a cycle early or late. The bench therefore reads status in the cycle before the expected edge and in the cycle of it.
- A damaged Gray crossing or base capture shows as a result far off the edge count the bench works out from the two clock periods. This is visible as soon as done rises.
- A divider fault shows as a wrong spacing between two consecutive `osc_div_en` pulses, within one divide period.
- Mask or decode faults show on the next read-back of the register concerned.

// File: rtl/ofm_pkg.sv
package ofm_pkg;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned DIV_W   = 6;
  localparam int unsigned SEL_BIT = 6;
  localparam logic [2:0]  IDX_CTRL = 3'd0;
  localparam logic [2:0]  IDX_WIN  = 3'd1;
  localparam logic [2:0]  IDX_SEL  = 3'd2;
  localparam logic [2:0]  IDX_STAT = 3'd4;
  localparam logic [2:0]  IDX_RES  = 3'd5;

  // bit i of cur is replaced by data[i] only where en[i] is set
  function automatic logic [7:0] merge_byte(input logic [7:0] cur,
                                            input logic [7:0] data,
                                            input logic [7:0] en);
    return (cur & ~en) | (data & en);
  endfunction

  // terminal count of the divider: field 0 behaves as divide-by-1
  function automatic logic [DIV_W-1:0] div_last(input logic [DIV_W-1:0] f);
    return (f == '0) ? '0 : f - 1'b1;
  endfunction
endpackage

// File: rtl/ofm_regs.sv
module ofm_regs
  import ofm_pkg::*;
#(
  parameter int unsigned WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       idx,
  input  logic [31:0]      wdata,
  output logic [7:0]       ctrl_q,
  output logic [WIN_W-1:0] win_q,
  output logic             sel_q,
  output logic             start_evt
);
  logic [7:0] ctrl_next;
  logic       sel_next;
  logic       ctrl_wr;

  assign ctrl_wr   = wr && (idx == IDX_CTRL);
  assign ctrl_next = merge_byte(ctrl_q, wdata[7:0], wdata[23:16]);
  assign sel_next  = wdata[16+SEL_BIT] ? wdata[SEL_BIT] : sel_q;
  // a start is a write that sets bit 0 and leaves both low bits high
  assign start_evt = ctrl_wr && wdata[16] && wdata[0] && (ctrl_next[1:0] == 2'b11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      win_q  <= '0;
      sel_q  <= 1'b0;
    end else if (wr) begin
      if (idx == IDX_CTRL) ctrl_q <= ctrl_next;
      if (idx == IDX_WIN)  win_q  <= wdata[WIN_W-1:0];
      if (idx == IDX_SEL)  sel_q  <= sel_next;
    end
  end
endmodule

// File: rtl/ofm_osc_count.sv
module ofm_osc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             run_req,
  output logic             run_s,
  output logic [CNT_W-1:0] gray_q
);
  logic             run_m;
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  function automatic logic [CNT_W-1:0] bin_to_gray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // enable crosses from the reference domain
  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_m <= 1'b0;
      run_s <= 1'b0;
    end else begin
      run_m <= run_req;
      run_s <= run_m;
    end
  end

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else if (run_s) begin
      bin_q  <= bin_nx;
      gray_q <= bin_to_gray(bin_nx);
    end
  end
endmodule

// File: rtl/ofm_divider.sv
module ofm_divider
  import ofm_pkg::*;
(
  input  logic             osc_clk,
  input  logic             rst_n,
  input  logic             run_s,
  input  logic [DIV_W-1:0] div_field,
  output logic             pulse_q
);
  logic [DIV_W-1:0] dcnt_q;
  logic [DIV_W-1:0] last;
  logic             wrap;

  assign last = div_last(div_field);
  assign wrap = (dcnt_q >= last);

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else if (!run_s) begin
      dcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else if (wrap) begin
      dcnt_q  <= '0;
      pulse_q <= 1'b1;
    end else begin
      dcnt_q  <= dcnt_q + 1'b1;
      pulse_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ofm_window.sv
module ofm_window #(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             start_evt,
  input  logic [WIN_W-1:0] win_len,
  input  logic [CNT_W-1:0] osc_gray,
  output logic             done_q,
  output logic [CNT_W-1:0] result_q
);
  logic [CNT_W-1:0] g_s1, g_s2;
  logic [CNT_W-1:0] bin_now;
  logic [CNT_W-1:0] base_q;
  logic [WIN_W-1:0] wcnt_q;
  logic [WIN_W-1:0] win_last;
  logic             win_end;

  function automatic logic [CNT_W-1:0] gray_to_bin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = int'(CNT_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [WIN_W-1:0] window_last(input logic [WIN_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_s1 <= '0;
      g_s2 <= '0;
    end else begin
      g_s1 <= osc_gray;
      g_s2 <= g_s1;
    end
  end

  assign bin_now  = gray_to_bin(g_s2);
  assign win_last = window_last(win_len);
  assign win_end  = arm && !done_q && (wcnt_q == win_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q   <= '0;
      done_q   <= 1'b0;
      base_q   <= '0;
      result_q <= '0;
    end else if (start_evt) begin
      wcnt_q <= '0;
      done_q <= 1'b0;
      base_q <= bin_now;
    end else if (!arm) begin
      wcnt_q <= '0;
      done_q <= 1'b0;
    end else if (win_end) begin
      done_q   <= 1'b1;
      result_q <= bin_now - base_q;
    end else if (!done_q) begin
      wcnt_q <= wcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
  import ofm_pkg::*;
#(
  parameter int unsigned WIN_W = 16,
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_clk,
  input  logic              ext_slow_clk,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              osc_run,
  output logic              osc_div_en,
  output logic              slow_src
);
  logic [2:0]       word_idx;
  logic [7:0]       ctrl_q;
  logic [WIN_W-1:0] win_q;
  logic             sel_q;
  logic             start_evt;
  logic             meas_arm;
  logic             run_s;
  logic [CNT_W-1:0] osc_gray;
  logic             done;
  logic [CNT_W-1:0] result;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign meas_arm = (ctrl_q[1:0] == 2'b11);
  assign osc_run  = ctrl_q[1];

  ofm_regs #(.WIN_W(WIN_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .idx(word_idx), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .win_q(win_q), .sel_q(sel_q), .start_evt(start_evt)
  );

  ofm_osc_count #(.CNT_W(CNT_W)) i_osc_count (
    .osc_clk(osc_clk), .rst_n(rst_n), .run_req(ctrl_q[1]),
    .run_s(run_s), .gray_q(osc_gray)
  );

  ofm_divider i_divider (
    .osc_clk(osc_clk), .rst_n(rst_n), .run_s(run_s),
    .div_field(ctrl_q[7:2]), .pulse_q(osc_div_en)
  );

  ofm_window #(.WIN_W(WIN_W), .CNT_W(CNT_W)) i_window (
    .clk(clk), .rst_n(rst_n), .arm(meas_arm), .start_evt(start_evt),
    .win_len(win_q), .osc_gray(osc_gray), .done_q(done), .result_q(result)
  );

  assign slow_src = sel_q ? osc_div_en : ext_slow_clk;

  always_comb begin
    bus_rdata = '0;
    case (word_idx)
      IDX_CTRL: bus_rdata = 32'(ctrl_q);
      IDX_WIN:  bus_rdata = 32'(win_q);
      IDX_SEL:  bus_rdata = 32'(sel_q) << SEL_BIT;
      IDX_STAT: bus_rdata = 32'(done);
      IDX_RES:  bus_rdata = 32'(result);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ofm_chk.sv
module ofm_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             osc_clk,
  input logic             meas_arm,
  input logic             start_evt,
  input logic             done,
  input logic [CNT_W-1:0] result,
  input logic             osc_div_en,
  input logic [5:0]       div_field
);
  // R4
  start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !done);
  // R4
  done_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(meas_arm));
  // R6
  clear_drops_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_arm |=> !done);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(result));
  // R9
  div_pulse_single_chk: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (osc_div_en && div_field > 6'd1) |=> !osc_div_en);
endmodule

bind osc_freq_meter ofm_chk #(.CNT_W(CNT_W)) i_ofm_chk (
  .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .meas_arm(meas_arm),
  .start_evt(start_evt), .done(done), .result(result),
  .osc_div_en(osc_div_en), .div_field(ctrl_q[7:2])
);

// File: tb/test_osc_freq_meter.sv
`timescale 1ns/1ps
module test_osc_freq_meter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_clk = 1'b0;
  logic        ext_slow_clk = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        osc_run, osc_div_en, slow_src;
  int          checks = 0;
  int          errors = 0;
  int          osc_half = 5;

  localparam logic [4:0] A_CTRL = 5'h00, A_WIN = 5'h04, A_SEL = 5'h08,
                         A_STAT = 5'h10, A_RES = 5'h14;

  osc_freq_meter i_osc_freq_meter (
    .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .ext_slow_clk(ext_slow_clk),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .osc_run(osc_run), .osc_div_en(osc_div_en),
    .slow_src(slow_src)
  );

  always #5 clk = ~clk;
  always #(osc_half) osc_clk = ~osc_clk;

  function automatic int exp_edges(input int win, input int half);
    int w;
    w = (win == 0) ? 1 : win;
    return (w * 10) / (2 * half);
  endfunction

  function automatic int exp_ratio(input int field);
    return (field == 0) ? 1 : field;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_near(input string tag, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic run_meas(input int win, input int half);
    logic [31:0] v, r1, r2;
    int w;
    w = (win == 0) ? 1 : win;
    osc_half = half;
    bus_write(A_WIN, 32'(win));
    bus_write(A_CTRL, 32'h0003_0002);
    repeat (20) @(negedge clk);
    bus_write(A_CTRL, 32'h0003_0003);
    if (w > 1) begin
      repeat (w - 1) @(negedge clk);
      bus_read(A_STAT, v);
      chk("R4 done early", v, 32'd0);
    end
    @(negedge clk);
    bus_read(A_STAT, v);
    chk("R4 done on time", v, 32'd1);
    bus_read(A_RES, r1);
    chk_near("R5 edge count", int'(r1), exp_edges(win, half), 2);
    repeat (7) @(negedge clk);
    bus_read(A_RES, r2);
    chk("R5 result frozen", r2, r1);
    bus_write(A_CTRL, 32'h0003_0000);
    @(negedge clk);
    bus_read(A_STAT, v);
    chk("R6 clear done", v, 32'd0);
  endtask

  task automatic div_check(input int field);
    int n;
    int guard;
    osc_half = 4;
    bus_write(A_CTRL, 32'h00FE_0000 | 32'(field << 2) | 32'h2);
    repeat (20) @(negedge clk);
    guard = 0;
    do begin @(negedge osc_clk); guard++; end while (!osc_div_en && guard < 200);
    n = 0;
    do begin @(negedge osc_clk); n++; end while (!osc_div_en && n < 200);
    chk_near("R9 pulse spacing", n, exp_ratio(field), 0);
    bus_write(A_CTRL, 32'h0002_0000);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_CTRL, v); chk("R1 ctrl", v, 0);
    bus_read(A_WIN, v);  chk("R1 win", v, 0);
    bus_read(A_SEL, v);  chk("R1 sel", v, 0);
    bus_read(A_STAT, v); chk("R1 stat", v, 0);
    bus_read(A_RES, v);  chk("R1 result", v, 0);
    chk("R1 osc_run", 32'(osc_run), 0);
    chk("R1 slow_src", 32'(slow_src), 1);

    // R2 masked writes on select
    bus_write(A_SEL, 32'h0040_FFFF);
    bus_read(A_SEL, v); chk("R2 sel set", v, 32'h40);
    bus_write(A_SEL, 32'hFFBF_0000);
    bus_read(A_SEL, v); chk("R2 sel masked", v, 32'h40);
    bus_write(A_SEL, 32'h0040_0000);
    bus_read(A_SEL, v); chk("R2 sel clear", v, 0);
    // R2 masked writes on control; upper bits unimplemented
    bus_write(A_CTRL, 32'h00FC_0057);
    bus_read(A_CTRL, v); chk("R2 ctrl field", v, 32'h54);
    bus_write(A_CTRL, 32'hFF00_FF00);
    bus_read(A_CTRL, v); chk("R2 ctrl upper", v, 32'h54);
    bus_write(A_CTRL, 32'h00FC_0000);

    // R3 window register width
    bus_write(A_WIN, 32'hABCD_1234);
    bus_read(A_WIN, v); chk("R3 win width", v, 32'h1234);

    // R8 oscillator only, no measurement
    bus_write(A_CTRL, 32'h0002_0002);
    chk("R8 osc_run", 32'(osc_run), 1);
    repeat (30) @(negedge clk);
    bus_read(A_STAT, v); chk("R8 no done", v, 0);
    bus_write(A_CTRL, 32'h0002_0000);

    // R3 zero length behaves as one
    run_meas(0, 5);
    // R4 R5 R6 directed and random windows
    run_meas(1, 7);
    run_meas(100, 3);
    for (int k = 0; k < 8; k++) begin
      run_meas(int'($urandom_range(2, 300)), int'($urandom_range(3, 20)));
    end

    // R11 writes to read-only registers
    osc_half = 6;
    bus_write(A_WIN, 32'd50);
    bus_write(A_CTRL, 32'h0003_0002);
    repeat (20) @(negedge clk);
    bus_write(A_CTRL, 32'h0003_0003);
    repeat (60) @(negedge clk);
    bus_read(A_RES, r);
    bus_write(A_RES, 32'hFFFF_FFFF);
    bus_write(A_STAT, 32'hFFFF_FFFE);
    bus_read(A_RES, v);  chk("R11 result kept", v, r);
    bus_read(A_STAT, v); chk("R11 status kept", v, 1);
    bus_read(A_CTRL, v); chk("R11 ctrl kept", v, 32'h3);

    // R7 restart mid-window
    bus_write(A_WIN, 32'd40);
    bus_write(A_CTRL, 32'h0001_0000);
    bus_write(A_CTRL, 32'h0001_0001);
    repeat (15) @(negedge clk);
    bus_write(A_CTRL, 32'h0001_0001);
    repeat (39) @(negedge clk);
    bus_read(A_STAT, v); chk("R7 restart not done", v, 0);
    @(negedge clk);
    bus_read(A_STAT, v); chk("R7 restart done", v, 1);
    bus_write(A_CTRL, 32'h0003_0000);

    // R9 divider
    div_check(0);
    div_check(1);
    div_check(5);
    div_check(int'($urandom_range(2, 30)));
    div_check(63);

    // R10 source select
    ext_slow_clk = 1'b0;
    @(negedge clk);
    chk("R10 ext low", 32'(slow_src), 0);
    ext_slow_clk = 1'b1;
    @(negedge clk);
    chk("R10 ext high", 32'(slow_src), 1);
    bus_write(A_SEL, 32'h0040_0040);
    chk("R10 internal idle", 32'(slow_src), 0);
    bus_write(A_CTRL, 32'h00FE_0002);
    repeat (10) @(negedge clk);
    ext_slow_clk = 1'b0;
    #1;
    chk("R10 internal div1", 32'(slow_src), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule